// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block gathers single-cycle event pulses from the receive-path error detectors and from other status sources into a bank of sticky status bits. A bit stays set until software reads the status register. The read returns the latched bits and clears them in the same access. The block drives one active-low interrupt request from the latched bits. The request is gated three ways: by a global enable, by a per-source enable mask, and by a mode that lets only the receive-cell error sources signal.

Status bits 0 to 2 are the receive-cell error sources. Bit 0 is a bad header checksum. Bit 1 is a short cell, meaning one that carried fewer than 53 bytes. Bit 2 is a received symbol error. The remaining bits hold other status conditions. For normal operation, with every unmasked source able to signal, the global enable is set and the receive-only mode is cleared. The event detectors and the register bus are outside this block. The block only needs the control byte, the mask and a read strobe.

Top module: `irq_status_ctrl`

## Requirements
- R1: After a clock edge with `rst_n` low, every status bit is 0, `irq_n_o` is 1 and `rd_data_o` is 0.
- R2: A 1 on `evt_i[k]` at a clock edge sets status bit k after that edge, whatever the mask, enable and mode. The bit stays set until a read clears it.
- R3: While `rd_stb_i` is 1, `rd_data_o` shows the status bits as they were before the edge. At that edge, every status bit is cleared unless R4 applies. While `rd_stb_i` is 0, `rd_data_o` is 0.
- R4: An event that arrives in the same cycle as a clearing read is set after that edge, so it is not lost.
- R5: When control bit 0 (global enable) is 0 at an edge, `irq_n_o` is 1 after that edge.
- R6: Mask bit k = 1 lets status bit k signal. Mask bit k = 0 stops status bit k from driving the interrupt, but the bit still latches.
- R7: When control bit 5 (receive-only mode) is 1, only status bits 0 to 2 can drive the interrupt. Every other bit is ignored even if its mask bit is 1.
- R8: `irq_n_o` is a register. After each edge it is 0 exactly when control bit 0 is 1 and some status bit, taking its value after that edge, is both set and allowed by R6 and R7. Control and mask are taken as sampled at that edge.
- R9: Control bits other than 0 and 5 have no effect on `irq_n_o` or on the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | 8 | Event pulses, one per status bit |
| ctrl_i | input | 8 | Control byte: bit 0 global enable, bit 5 receive-only mode |
| mask_i | input | 8 | Per-source enable mask, 1 = may signal |
| rd_stb_i | input | 1 | Status read strobe, clears on the edge that ends it |
| rd_data_o | output | 8 | Status bits while strobe is high, else 0 |
| irq_n_o | output | 1 | Interrupt request, active low, registered |

## Verification
The case where two functions meet in one cycle is a clearing read together with a fresh event pulse. It can hit the bit being read or a different bit. The bench provokes it with a directed read carrying an event on bit 1. It then fires random reads and events at a high rate so that many such collisions occur. A behavioural model applies clear-then-set on every edge. On each clock the bench judges the collision by the interrupt output, and after the next read by the data the status register returns.

// File: rtl/irq_status_pkg.sv
// Package: shared widths and control-bit positions for the interrupt
// status controller. Assumes an 8-bit control byte.
package irq_status_pkg;
    localparam int CTRL_W          = 8;
    localparam int CTRL_EN_BIT     = 0;
    localparam int CTRL_RXONLY_BIT = 5;
endpackage

// File: rtl/irq_sticky_bank.sv
// Module: irq_sticky_bank
// Holds one sticky status bit per source. A read strobe clears the bank and an
// event in the same cycle wins over the clear. Also exposes the next-state
// vector so the interrupt path can follow status without a cycle of lag.
// Assumes: events are level-sampled once per clock; synchronous active-low reset.
module irq_sticky_bank #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               rd_i,
    output logic [NUM_SRC-1:0] stat_q,
    output logic [NUM_SRC-1:0] stat_nxt
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        // Next value: cleared by a read, set by an event (set dominates).
        always_comb begin
            stat_nxt[i] = (stat_q[i] & ~rd_i) | evt_i[i];
        end

        // Status flop for source i.
        always_ff @(posedge clk) begin
            if (!rst_n) stat_q[i] <= 1'b0;
            else        stat_q[i] <= stat_nxt[i];
        end

        // R2
        evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[i] |=> stat_q[i]);
        // R3
        rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_i && !evt_i[i]) |=> !stat_q[i]);
        // R2
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!rd_i && !evt_i[i]) |=> $stable(stat_q[i]));
    end
endmodule

// File: rtl/irq_gate.sv
// Module: irq_gate
// Decides whether the status vector requests an interrupt. It applies the
// per-source mask, the receive-only mode and the global enable.
// Assumes: RX_SRCS marks which bits are receive-cell error sources.
module irq_gate
    import irq_status_pkg::*;
#(
    parameter int                  NUM_SRC = 8,
    parameter logic [NUM_SRC-1:0]  RX_SRCS = 8'h07
) (
    input  logic [NUM_SRC-1:0] stat_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic [CTRL_W-1:0]  ctrl_i,
    output logic               req_o
);
    logic [NUM_SRC-1:0] elig;
    logic               rx_only;

    // Mode bit pulled out of the control byte.
    always_comb rx_only = ctrl_i[CTRL_RXONLY_BIT];

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
        // Per-source eligibility: unmasked, and a receive source when in receive-only mode.
        always_comb elig[i] = stat_i[i] & mask_i[i] & (RX_SRCS[i] | ~rx_only);
    end

    // Global enable over the reduced eligible set.
    always_comb req_o = ctrl_i[CTRL_EN_BIT] & (|elig);
endmodule

// File: rtl/irq_out_reg.sv
// Module: irq_out_reg
// Registers the active-low interrupt pin. It is held high in reset.
// Assumes: req_i is already fully gated.
module irq_out_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic irq_n_o
);
    // Output flop, inverted sense.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n_o <= 1'b1;
        else        irq_n_o <= ~req_i;
    end
endmodule

// File: rtl/irq_status_ctrl.sv
// Module: irq_status_ctrl (top)
// Builds the sticky status bank, the interrupt gate and the output register.
// Read data is the pre-clear status, presented while the strobe is high.
// Assumes: one read strobe cycle per access; synchronous active-low reset.
module irq_status_ctrl
    import irq_status_pkg::*;
#(
    parameter int                 NUM_SRC = 8,
    parameter logic [NUM_SRC-1:0] RX_SRCS = 8'h07
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [CTRL_W-1:0]  ctrl_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic               rd_stb_i,
    output logic [NUM_SRC-1:0] rd_data_o,
    output logic               irq_n_o
);
    logic [NUM_SRC-1:0] stat_q;
    logic [NUM_SRC-1:0] stat_nxt;
    logic               req;

    irq_sticky_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .rd_i     (rd_stb_i),
        .stat_q   (stat_q),
        .stat_nxt (stat_nxt)
    );

    irq_gate #(.NUM_SRC(NUM_SRC), .RX_SRCS(RX_SRCS)) u_gate (
        .stat_i (stat_nxt),
        .mask_i (mask_i),
        .ctrl_i (ctrl_i),
        .req_o  (req)
    );

    irq_out_reg u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .irq_n_o (irq_n_o)
    );

    // Read data mux: status only during a read strobe.
    always_comb rd_data_o = rd_stb_i ? stat_q : '0;

    // R5
    en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_i[CTRL_EN_BIT] |=> irq_n_o);
    // R7
    rx_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i[CTRL_RXONLY_BIT] && ((stat_nxt & RX_SRCS) == '0)) |=> irq_n_o);
    // R4
    rd_evt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && (evt_i != '0)) |=> (stat_q != '0));
endmodule

// File: tb/sim_irq_status_ctrl.sv
module sim_irq_status_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt = '0, ctrl = '0, mask = '0;
    logic       rd = 1'b0;
    logic [7:0] rd_data;
    logic       irq_n;

    int n_cmp = 0, n_bad = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    irq_status_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .ctrl_i(ctrl), .mask_i(mask),
        .rd_stb_i(rd), .rd_data_o(rd_data), .irq_n_o(irq_n)
    );

    // Behavioural reference: integers and plain arithmetic.
    int m_stat = 0;
    int m_irq_n = 1;
    always @(posedge clk) begin
        int nxt, elig;
        if (!rst_n) begin
            m_stat = 0; m_irq_n = 1;
        end else begin
            nxt = (rd ? 0 : m_stat) | int'(evt);
            elig = int'(mask) & (ctrl[5] ? 7 : 255);
            m_stat = nxt;
            m_irq_n = (ctrl[0] && ((nxt & elig) != 0)) ? 0 : 1;
        end
    end

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One cycle: compare irq, drive new inputs, compare read data.
    task automatic step(logic [7:0] e, logic r, logic [7:0] c, logic [7:0] m);
        @(negedge clk);
        chk(cur_req, int'(irq_n), m_irq_n);
        evt = e; rd = r; ctrl = c; mask = m;
        #1;
        chk(cur_req, int'(rd_data), r ? m_stat : 0);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cur_req = "R1";
        step(0, 1, 0, 0);
        chk("R1", int'(rd_data), 0);
        chk("R1", int'(irq_n), 1);
        // R2: latch with mask and enable off
        cur_req = "R2";
        step(8'h08, 0, 0, 0);
        step(0, 0, 0, 0);
        step(0, 1, 0, 0);
        chk("R2", int'(rd_data), 8'h08);
        // R5: enable off keeps irq high
        cur_req = "R5";
        step(8'h10, 0, 8'h00, 8'hFF);
        step(0, 0, 8'h00, 8'hFF);
        chk("R5", int'(irq_n), 1);
        // R8: enabling asserts irq one edge later
        cur_req = "R8";
        step(0, 0, 8'h01, 8'hFF);
        step(0, 0, 8'h01, 8'hFF);
        chk("R8", int'(irq_n), 0);
        // R3: read clears and releases
        cur_req = "R3";
        step(0, 1, 8'h01, 8'hFF);
        chk("R3", int'(rd_data), 8'h10);
        step(0, 0, 8'h01, 8'hFF);
        chk("R3", int'(irq_n), 1);
        // R4: event during read survives
        cur_req = "R4";
        step(8'h02, 1, 8'h01, 8'hFF);
        step(0, 1, 8'h01, 8'hFF);
        chk("R4", int'(rd_data), 8'h02);
        // R6: masked source latches but does not signal
        cur_req = "R6";
        step(8'h40, 0, 8'h01, 8'hBF);
        step(0, 0, 8'h01, 8'hBF);
        chk("R6", int'(irq_n), 1);
        step(0, 1, 8'h01, 8'hBF);
        chk("R6", int'(rd_data), 8'h40);
        // R7: receive-only mode
        cur_req = "R7";
        step(8'h80, 0, 8'h21, 8'hFF);
        step(0, 0, 8'h21, 8'hFF);
        chk("R7", int'(irq_n), 1);
        step(8'h04, 0, 8'h21, 8'hFF);
        step(0, 0, 8'h21, 8'hFF);
        chk("R7", int'(irq_n), 0);
        step(0, 0, 8'h01, 8'hFF);
        step(0, 1, 8'h01, 8'hFF);
        // R9: other control bits inert
        cur_req = "R9";
        step(8'h20, 0, 8'hDF, 8'hFF);
        step(0, 0, 8'hDF, 8'hFF);
        chk("R9", int'(irq_n), 0);
        step(0, 1, 8'hDE, 8'hFF);
        chk("R9", int'(rd_data), 8'h20);
        // R4 R8: random traffic with frequent read/event collisions
        cur_req = "R4/R8 random";
        for (int k = 0; k < 400; k++)
            step(($urandom % 3 == 0) ? 8'($urandom) : 8'h00, ($urandom % 3) == 0,
                 8'($urandom), 8'($urandom));
        // R1: reset mid-run
        cur_req = "R1";
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; rd = 1'b1;
        #1;
        chk("R1", int'(irq_n), 1);
        chk("R1", int'(rd_data), 0);
        step(0, 0, 0, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule